// File: doc/BRIEF.md
# UART Fractional Baud Generator

This block derives the timing for a UART from a source clock. It produces a sample tick at sixteen times the baud rate, a bit-start tick, and a four-bit sample index. The divisor has two parts. The integer part sets the base length of each of the sixteen sub-bit periods. A 16-bit slot mask lengthens selected sub-bit periods by one clock each, which gives the divide ratio a resolution of one sixteenth.

To choose the settings, compute the ideal value source_clock / (baud × 16) − 1. The integer divisor is its whole part. The slot mask holds as many ones as sixteen times the fractional part, rounded down. For example, a fraction of 0.83 gives 13 ones: an integer divisor of 51 with mask 0xDFDD. The generator copies new settings into its working registers only when the sample index wraps, so every bit period runs on a single setting. A framing unit, such as an 8N1 serializer, uses the two ticks and the index.

Top module: `uart_frac_baud_gen`

## Requirements
- R1: While rst_n is low, samp_tick and bit_tick are 0 and samp_idx is 0.
- R2: After reset is released, the first rising edge only loads div_int and slot_mask. The first samp_tick is high in the cycle after rising edge number div+1+mask[0], counted from release, with samp_idx = 0.
- R3: A sub-bit period whose mask bit is 0 lasts div+1 clocks between consecutive samp_tick pulses.
- R4: A sub-bit period whose mask bit is 1 lasts div+2 clocks. Mask bit i belongs to sample index i, with bit 0 belonging to index 0.
- R5: samp_idx holds between ticks. It steps by one on each samp_tick and wraps from 15 to 0.
- R6: bit_tick is high exactly in the cycles where samp_tick ends sample index 15.
- R7: One bit period, measured between bit_tick pulses, lasts 16·(div+1) + popcount(mask) clocks. For example, div 51 with mask 0xDFDD gives 845.
- R8: Changing div_int or slot_mask in the middle of a bit does not affect that bit. The new values apply from the bit that starts after the next bit_tick.
- R9: With div = 0 and mask = 0, samp_tick is high on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_int | input | DIV_W | Integer divisor (sub-period length minus one) |
| slot_mask | input | 16 | Mask of sub-periods lengthened by one clock |
| samp_tick | output | 1 | One-clock pulse ending each sub-bit period |
| bit_tick | output | 1 | One-clock pulse marking the start of a bit period |
| samp_idx | output | 4 | Index of the current sub-bit period |

## Verification
The assertions check the following on every cycle:
- the sub-period counter stays below the active length;
- the index steps by exactly one and wraps only to 0;
- the active settings stay unchanged between wraps;
- bit_tick only accompanies the end of index 15.

The scenarios alone show the absolute clock counts: the delay to the first tick after reset, the length of each sub-period under each mask bit, and the total bit lengths. They also show that a mid-bit change of the settings takes effect at the next bit.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
  localparam int unsigned SLOT_COUNT = 16;
  localparam int unsigned IDX_W      = $clog2(SLOT_COUNT);

  typedef enum logic {
    PH_ARM = 1'b0,
    PH_RUN = 1'b1
  } ubg_phase_e;
endpackage

// File: rtl/ubg_settings.sv
module ubg_settings
  import ubg_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrap,
  input  logic [DIV_W-1:0]      div_in,
  input  logic [SLOT_COUNT-1:0] mask_in,
  output logic [DIV_W-1:0]      div_q,
  output logic [SLOT_COUNT-1:0] mask_q,
  output logic                  running
);
  ubg_phase_e            phase_q, phase_d;
  logic [DIV_W-1:0]      div_d;
  logic [SLOT_COUNT-1:0] mask_d;
  logic                  load;

  // Settings are taken once on arming and afterwards only at a bit boundary
  assign load = (phase_q == PH_ARM) || wrap;

  always_comb begin
    phase_d = PH_RUN;
    div_d   = div_q;
    mask_d  = mask_q;
    if (load) begin
      div_d  = div_in;
      mask_d = mask_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ARM;
      div_q   <= '0;
      mask_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (load) begin
        div_q  <= div_d;
        mask_q <= mask_d;
      end
    end
  end

  assign running = (phase_q == PH_RUN);

  // R8
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(div_q) && $stable(mask_q)));

  // R2
  arm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
endmodule

// File: rtl/ubg_sub_timer.sv
module ubg_sub_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             sub_end
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign sub_end = run && (cnt_q == (len - CNT_W'(1)));
  assign cnt_en  = run;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    if (sub_end) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < len));

  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cnt_q == '0));
endmodule

// File: rtl/ubg_index.sv
module ubg_index
  import ubg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx_q,
  output logic             wrap
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOT_COUNT - 1);

  logic [IDX_W-1:0] idx_d;

  assign wrap  = step && (idx_q == LAST);
  assign idx_d = wrap ? '0 : idx_q + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= idx_d;
    end
  end

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (idx_q != LAST)) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

  // R5
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (idx_q == '0));

  // R5
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx_q));
endmodule

// File: rtl/uart_frac_baud_gen.sv
module uart_frac_baud_gen
  import ubg_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      div_int,
  input  logic [SLOT_COUNT-1:0] slot_mask,
  output logic                  samp_tick,
  output logic                  bit_tick,
  output logic [IDX_W-1:0]      samp_idx
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [DIV_W-1:0]      div_q;
  logic [SLOT_COUNT-1:0] mask_q;
  logic                  running;
  logic [IDX_W-1:0]      idx;
  logic                  wrap;
  logic                  sub_end;
  logic [CNT_W-1:0]      len;

  ubg_settings #(.DIV_W(DIV_W)) u_settings (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap),
    .div_in  (div_int),
    .mask_in (slot_mask),
    .div_q   (div_q),
    .mask_q  (mask_q),
    .running (running)
  );

  // Length of the current sub-bit period: base plus the slot's extra clock
  assign len = {1'b0, div_q} + CNT_W'(1) + CNT_W'(mask_q[idx]);

  ubg_sub_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .len     (len),
    .sub_end (sub_end)
  );

  ubg_index u_index (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (sub_end),
    .idx_q (idx),
    .wrap  (wrap)
  );

  assign samp_tick = sub_end;
  assign bit_tick  = wrap;
  assign samp_idx  = idx;

  // R6
  bit_tick_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (samp_tick && (samp_idx == IDX_W'(SLOT_COUNT - 1))));

  // R2
  no_tick_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!samp_tick && !bit_tick));
endmodule

// File: tb/uart_frac_baud_gen_test.sv
module uart_frac_baud_gen_test;
  localparam int DIV_W = 16;
  localparam int NV    = 7;
  // {div, mask, expected bit length}
  localparam logic [47:0] VEC [NV] = '{
    {16'd0,  16'h0000, 16'd16},
    {16'd0,  16'hFFFF, 16'd32},
    {16'd3,  16'h0000, 16'd64},
    {16'd3,  16'h8001, 16'd66},
    {16'd51, 16'hDFDD, 16'd845},
    {16'd7,  16'h00FF, 16'd136},
    {16'd2,  16'hAAAA, 16'd56}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div_int = '0;
  logic [15:0]      slot_mask = '0;
  logic             samp_tick, bit_tick;
  logic [3:0]       samp_idx;

  int checks = 0;
  int fails  = 0;

  uart_frac_baud_gen #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .slot_mask(slot_mask),
    .samp_tick(samp_tick), .bit_tick(bit_tick), .samp_idx(samp_idx)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bit();
    do @(negedge clk); while (!bit_tick);
  endtask

  // Called at the negedge where a bit_tick was seen; measures the next bit
  task automatic measure_bit(input logic [15:0] d, input logic [15:0] m, output int period);
    int gap;
    int nidx;
    gap = 0; nidx = 0; period = 0;
    do begin
      @(negedge clk);
      period++; gap++;
      if (samp_tick) begin
        chk(samp_idx == 4'(nidx), "R5", samp_idx, nidx);
        chk(gap == int'(d) + 1 + int'(m[nidx]), m[nidx] ? "R4" : "R3",
            gap, int'(d) + 1 + int'(m[nidx]));
        chk(bit_tick == (nidx == 15), "R6", bit_tick, nidx == 15);
        gap = 0;
        nidx = (nidx + 1) % 16;
      end
    end while (!bit_tick && period < 5000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int p;
    // R1: outputs idle in reset
    div_int = 16'd3; slot_mask = 16'h0001;
    repeat (3) @(negedge clk);
    chk(samp_tick == 0, "R1", samp_tick, 0);
    chk(bit_tick == 0, "R1", bit_tick, 0);
    chk(samp_idx == 0, "R1", samp_idx, 0);

    // R2: first tick after div+1+mask[0] = 5 edges
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!samp_tick && n < 100);
    chk(n == 5, "R2", n, 5);
    chk(samp_idx == 0, "R2", samp_idx, 0);

    // R7 table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      div_int   = VEC[i][47:32];
      slot_mask = VEC[i][31:16];
      wait_bit();
      measure_bit(VEC[i][47:32], VEC[i][31:16], p);
      chk(p == int'(VEC[i][15:0]), "R7", p, int'(VEC[i][15:0]));
    end

    // R8: mid-bit change ignored until next bit
    @(negedge clk);
    div_int = 16'd3; slot_mask = 16'h0000;
    wait_bit();
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 7) begin div_int = 16'd0; slot_mask = 16'hFFFF; end
    end while (!bit_tick && n < 5000);
    chk(n == 64, "R8", n, 64);
    measure_bit(16'd0, 16'hFFFF, p);
    chk(p == 32, "R8", p, 32);

    // R9: tick on every clock
    @(negedge clk);
    div_int = 16'd0; slot_mask = 16'h0000;
    wait_bit();
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (samp_tick) n++;
    end
    chk(n == 20, "R9", n, 20);

    // R1: reset mid-run clears outputs at once
    rst_n = 1'b0;
    #1;
    chk(samp_tick == 0, "R1", samp_tick, 0);
    chk(samp_idx == 0, "R1", samp_idx, 0);
    @(negedge clk);
    chk(bit_tick == 0, "R1", bit_tick, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule